// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address of every data phase in a memory-space burst. A target loads it once per transaction with the start address and its programmed cache-line size. The two least significant bits of that start address carry a code that picks the order in which the words are visited. After the load, every completed data phase advances the block to the next word address. The output is always a byte address with its two lowest bits cleared.

Three orders are provided. Linear order counts upward. Toggle order forms each word index by XORing the start word index with a running word count. Wrap order visits the words of the current cache line circularly, starting from the requested word, and then moves to the same offset in the following line.

A wide mode moves two words per data phase. The block raises a registered single-word flag when it cannot honour the request, so that the target can end the burst after the first word. This happens for the reserved order code, for wrap order with a line size it does not support, and for a wide transfer whose start is not aligned to two words.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next value of `addr_o` is 0 and of `single_o` is 0.
- R2: A cycle with `load_i` high captures `start_i`, `line_words_i` and `wide_i`. In the next cycle, `addr_o` equals `start_i` with bits [1:0] cleared. `start_i[1:0]` is the order code: 00 linear, 01 reserved, 10 toggle, 11 wrap.
- R3: In linear order, with word count n (words moved since the load), the word index is the start word index plus n.
- R4: In toggle order, the word index is the start word index XOR n. The line size has no effect, so toggle order never raises `single_o` because of the line size.
- R5: In wrap order with line size L, offset o = start word index mod L and line base b = start word index minus o. The word index is b + L*floor(n/L) + ((o + n) mod L).
- R6: When the start word index is a multiple of L, linear, toggle and wrap orders give the same word indices for the first L words of the burst.
- R7: Order code 01 sets `single_o` to 1 in the cycle after the load.
- R8: Wrap order with a line size other than 4, 8 or 16 words sets `single_o` to 1. Toggle and linear orders are not affected by the line size.
- R9: When `wide_i` is captured high, n grows by 2 per data phase. If `start_i[2]` is 1 in wide mode, `single_o` is set to 1.
- R10: `addr_o` changes only in the cycle after a load or after a transfer strobe. While `single_o` is 1, a transfer strobe leaves `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures a new burst start |
| start_i | input | ADDR_W | Start byte address; bits [1:0] hold the order code |
| line_words_i | input | LINE_W | Programmed cache-line size in words |
| wide_i | input | 1 | Two words per data phase |
| xfer_i | input | 1 | A data phase completed |
| addr_o | output | ADDR_W | Current word address, bits [1:0] zero |
| single_o | output | 1 | Request unsupported; end after the first word |

## Verification
The assertions assume that `load_i` and `xfer_i` are never high in the same cycle, and that the line size and wide setting matter only at the load. The bench keeps to these assumptions. It changes the configuration only together with a load and drives strobes in separate cycles. It sweeps every order code, line sizes from 0 to 17, sixteen start offsets and both widths. Idle cycles are inserted between transfers so that the hold behaviour is observed at the outputs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ORD_LIN = 2'b00,
    ORD_RSV = 2'b01,
    ORD_TGL = 2'b10,
    ORD_WRP = 2'b11
  } order_e;
endpackage

// File: rtl/burst_seq_cfg.sv
module burst_seq_cfg
  import burst_seq_pkg::*;
#(
  parameter int WW       = 30,
  parameter int LINE_W   = 8,
  parameter int MIN_LINE = 4,
  parameter int MAX_LINE = 16
) (
  input  order_e            order_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wide_i,
  input  logic              word0_i,
  output logic              unsup_o,
  output logic [WW-1:0]     mask_o
);
  logic pow2;
  logic in_range;
  logic line_ok;

  always_comb begin
    pow2     = (line_i != '0) && ((line_i & (line_i - 1'b1)) == '0);
    in_range = (32'(line_i) >= MIN_LINE) && (32'(line_i) <= MAX_LINE);
    line_ok  = pow2 && in_range;
    mask_o   = line_ok ? (WW'(line_i) - 1'b1) : '0;
    unsup_o  = (order_i == ORD_RSV)
             || ((order_i == ORD_WRP) && !line_ok)
             || (wide_i && word0_i);
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int WW = 30
) (
  input  order_e        order_i,
  input  logic [WW-1:0] base_i,
  input  logic [WW-1:0] cnt_i,
  input  logic [WW-1:0] mask_i,
  output logic [WW-1:0] word_o
);
  logic [WW-1:0] line_part;
  logic [WW-1:0] in_part;

  always_comb begin
    line_part = (base_i & ~mask_i) + (cnt_i & ~mask_i);
    in_part   = ((base_i & mask_i) + (cnt_i & mask_i)) & mask_i;
    case (order_i)
      ORD_TGL: word_o = base_i ^ cnt_i;
      ORD_WRP: word_o = line_part | in_part;
      default: word_o = base_i + cnt_i;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 8,
  parameter int MIN_LINE = 4,
  parameter int MAX_LINE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LINE_W-1:0] line_words_i,
  input  logic              wide_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              single_o
);
  localparam int WW = ADDR_W - 2;

  order_e        order_q;
  logic [WW-1:0] base_q;
  logic [WW-1:0] mask_q;
  logic [WW-1:0] cnt_q;
  logic          wide_q;
  logic          single_q;
  logic [ADDR_W-1:0] addr_q;

  order_e        ld_order;
  logic          ld_unsup;
  logic [WW-1:0] ld_mask;
  logic [WW-1:0] cnt_nx;
  logic [WW-1:0] word_nx;

  assign ld_order = order_e'(start_i[1:0]);
  assign cnt_nx   = cnt_q + (wide_q ? WW'(2) : WW'(1));

  burst_seq_cfg #(
    .WW(WW), .LINE_W(LINE_W), .MIN_LINE(MIN_LINE), .MAX_LINE(MAX_LINE)
  ) u_cfg (
    .order_i (ld_order),
    .line_i  (line_words_i),
    .wide_i  (wide_i),
    .word0_i (start_i[2]),
    .unsup_o (ld_unsup),
    .mask_o  (ld_mask)
  );

  burst_seq_gen #(.WW(WW)) u_gen (
    .order_i (order_q),
    .base_i  (base_q),
    .cnt_i   (cnt_nx),
    .mask_i  (mask_q),
    .word_o  (word_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q  <= ORD_LIN;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      wide_q   <= 1'b0;
      single_q <= 1'b0;
      addr_q   <= '0;
    end else if (load_i) begin
      order_q  <= ld_order;
      base_q   <= start_i[ADDR_W-1:2];
      mask_q   <= ld_mask;
      cnt_q    <= '0;
      wide_q   <= wide_i;
      single_q <= ld_unsup;
      addr_q   <= {start_i[ADDR_W-1:2], 2'b00};
    end else if (xfer_i && !single_q) begin
      cnt_q    <= cnt_nx;
      addr_q   <= {word_nx, 2'b00};
    end
  end

  assign addr_o   = addr_q;
  assign single_o = single_q;

  // R3: a linear step adds one or two words to the address
  p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!single_q && order_q == ORD_LIN && xfer_i && !load_i)
    |=> addr_o == $past(addr_o) + ADDR_W'(wide_q ? 8 : 4));

  // R7: the reserved code forces single-word access
  p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    (load_i && start_i[1:0] == 2'b01) |=> single_o);

  // R9: an accepted wide burst stays two-word aligned
  p_wide_align_r9: assert property (@(posedge clk) disable iff (rst)
    (wide_q && !single_o) |-> !addr_o[2]);

  // R10: without load or transfer the address holds
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !xfer_i) |=> $stable(addr_o));

  // R10: a strobe has no effect once single-word access is forced
  p_single_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (single_q && xfer_i && !load_i) |=> $stable(addr_o));
endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 8;
  localparam int NXFER  = 12;
  localparam logic [29:0] BASE_WORD = 30'h048D15A0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] start_i = '0;
  logic [LINE_W-1:0] line_words_i = '0;
  logic              wide_i = 1'b0;
  logic              xfer_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              single_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
    .line_words_i(line_words_i), .wide_i(wide_i), .xfer_i(xfer_i),
    .addr_o(addr_o), .single_o(single_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] model(input int code, input int L,
                                        input logic [29:0] s, input int n);
    int o;
    logic [29:0] b;
    case (code)
      2: model = s ^ 30'(n);
      3: begin
        o = int'(s % 30'(L));
        b = s - 30'(o);
        model = b + 30'(L * (n / L)) + 30'((o + n) % L);
      end
      default: model = s + 30'(n);
    endcase
  endfunction

  task automatic burst(input int code, input int L, input int off, input bit wide);
    logic [29:0] s;
    bit exp_single;
    int n;
    string tag;
    s = BASE_WORD + 30'(off);
    exp_single = (code == 1) ||
                 (code == 3 && !(L == 4 || L == 8 || L == 16)) ||
                 (wide && s[0]);
    tag = (code == 0) ? "R3" : (code == 2) ? "R4" : (code == 3) ? "R5" : "R7";
    @(negedge clk);
    load_i = 1'b1;
    start_i = {s, 2'(code)};
    line_words_i = LINE_W'(L);
    wide_i = wide;
    @(negedge clk);
    load_i = 1'b0;
    check("R2 start", addr_o, {s, 2'b00});
    if (code == 1) check("R7 reserved", 32'(single_o), 32'(exp_single));
    else if (wide && s[0]) check("R9 misaligned wide", 32'(single_o), 32'(exp_single));
    else check("R8 single flag", 32'(single_o), 32'(exp_single));
    n = 0;
    for (int k = 1; k <= NXFER; k++) begin
      xfer_i = 1'b1;
      @(negedge clk);
      xfer_i = 1'b0;
      if (exp_single) begin
        check("R10 single hold", addr_o, {s, 2'b00});
      end else begin
        n += wide ? 2 : 1;
        if (wide) check("R9 wide step", addr_o, {model(code, L, s, n), 2'b00});
        else check(tag, addr_o, {model(code, L, s, n), 2'b00});
        if (code != 1 && (off % 16) == 0 && (L == 4 || L == 8 || L == 16) && n < L)
          check("R6 offset zero", addr_o, {s + 30'(n), 2'b00});
      end
      if (k % 4 == 0) begin
        @(negedge clk);
        check("R10 idle hold", addr_o,
              exp_single ? {s, 2'b00} : {model(code, L, s, n), 2'b00});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset addr", addr_o, 32'h0);
    check("R1 reset single", 32'(single_o), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int code = 0; code < 4; code++)
      for (int L = 0; L < 18; L++)
        for (int off = 0; off < 16; off++)
          for (int w = 0; w < 2; w++)
            burst(code, L, off, w[0]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule